// File: doc/BRIEF.md
# Switch-Configured Banked RAM Expansion

This block models an 8 KiB static RAM expansion that sits on a processor bus with a 16-bit address and an 8-bit data path. Six static configuration inputs stand in for DIP switches. They are read as three complementary pairs, and each pair fixes one of the top three address bits of the window base. The window can therefore be placed on any 8 KiB boundary from 0x0000 up to 0xE000.

Inside the window a 3-to-8 decoder drives one-hot enables for eight banks of 1K x 8. Each bank is eight 1024 x 1 bit-slice arrays, one per data bit. The processor data is split into two one-way paths. A write path carries `wdata_i` into the slices. A read path returns the selected bank's byte on `rdata_o` through a tri-state driver that is enabled only for valid reads that hit the window. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `swcfg_bank_ram`

## Requirements
- R1: The window matches when addr_i[15:13] equals the base set by the switches. Each pair decodes as (sw_i[2p], sw_i[2p+1]) = (1,0) for a 0 bit and (0,1) for a 1 bit. Pair sw_i[1:0] sets A15, sw_i[3:2] sets A14 and sw_i[5:4] sets A13.
- R2: If any switch pair reads (1,1) or (0,0), the block never responds: bank_ce_o stays 0, rdata_oe_o stays 0 and no write happens.
- R3: During a valid cycle that matches the window, bank_ce_o has exactly bit addr_i[12:10] set. At all other times it is 0.
- R4: A valid write (cyc_valid_i=1, rd_i=0) that matches the window stores wdata_i at the rising edge. The byte goes into bank addr_i[12:10] at offset addr_i[9:0], and every other location is left unchanged.
- R5: A valid read (cyc_valid_i=1, rd_i=1) that matches the window drives rdata_o with the stored byte in the same cycle and sets rdata_oe_o=1. Otherwise rdata_o is all high impedance and rdata_oe_o=0.
- R6: A write cycle outside the window, or any cycle with cyc_valid_i=0, changes no stored byte.
- R7: While rst_n is low, no write takes effect.
- R8: Storage is indexed only by the in-window offset. After the base is moved, the same bytes are read at the new window addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; blocks writes while low |
| sw_i | input | 6 | Base switches, three complementary pairs (1 = on) |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Write data path into the RAM |
| rd_i | input | 1 | 1 = read cycle, 0 = write cycle |
| cyc_valid_i | input | 1 | Bus cycle is valid |
| rdata_o | output | 8 | Tri-state read data path back to the bus |
| rdata_oe_o | output | 1 | Read driver enabled |
| bank_ce_o | output | 8 | One-hot bank enables |

## Verification
A wrong window decode or bank decode shows up at once on `bank_ce_o` and `rdata_oe_o` in the same cycle as the address. A misdirected write stays hidden in storage until the affected location is read back, so the bench reads every bank after each series of writes. It also re-reads in-window data after writes that hit outside the window or are invalid. Bit-slice wiring faults appear as single-bit errors in the returned byte, and the distinct per-bank patterns expose them.

// File: rtl/swcfg_ram_pkg.sv
// Package: shared sizes and the switch-pair decode used by the window logic.
// Assumes: a pair is exactly two inputs; a "1" input means the switch is on.
package swcfg_ram_pkg;

    typedef struct packed {
        logic ok;   // pair holds a legal complementary setting
        logic bit_v; // decoded address bit
    } pair_dec_t;

    // Decode one complementary switch pair: (on,off) -> 0, (off,on) -> 1.
    function automatic pair_dec_t decode_pair(input logic first_on, input logic second_on);
        pair_dec_t r;
        r.ok    = first_on ^ second_on;
        r.bit_v = second_on;
        return r;
    endfunction

endpackage

// File: rtl/swcfg_window_decode.sv
// Module: window match and bank enable decode.
// Decodes the switch pairs into a base, compares it with the upper address
// bits, and turns the bank-select field into one-hot enables.
// Assumes: sw_i is static during a cycle; enables are combinational.
module swcfg_window_decode
    import swcfg_ram_pkg::*;
#(
    parameter int WIN_W = 3,
    parameter int SEL_W = 3,
    localparam int SW_W   = 2 * WIN_W,
    localparam int BANK_N = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW_W-1:0]   sw_i,
    input  logic [WIN_W-1:0]  win_bits_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              cyc_valid_i,
    output logic              match_o,
    output logic [BANK_N-1:0] bank_ce_o
);

    logic [WIN_W-1:0] base_bits;
    logic [WIN_W-1:0] pair_ok;

    // Pair p sets window bit WIN_W-1-p (the first pair sets the top bit).
    for (genvar p = 0; p < WIN_W; p++) begin : g_pair
        pair_dec_t dec;
        always_comb dec = decode_pair(sw_i[2*p], sw_i[2*p+1]);
        assign base_bits[WIN_W-1-p] = dec.bit_v;
        assign pair_ok[WIN_W-1-p]   = dec.ok;

        // R2: an illegal pair never produces a window match
        a_r2_bad_pair: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_i[2*p] == sw_i[2*p+1]) |-> !match_o);
    end

    // Match only when every pair is legal and the base equals the address.
    always_comb match_o = (&pair_ok) && (base_bits == win_bits_i);

    // One-hot bank enable for a valid matched cycle.
    always_comb begin
        bank_ce_o = '0;
        if (match_o && cyc_valid_i)
            bank_ce_o[sel_i] = 1'b1;
    end

    // R3: never more than one bank enabled
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_ce_o));

    // R3: a valid matched cycle enables exactly one bank
    a_r3_one_when_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && cyc_valid_i) |-> ($countones(bank_ce_o) == 1));

endmodule

// File: rtl/swcfg_bit_slice.sv
// Module: one DEPTH x 1 storage slice with a registered write and an
// asynchronous read. Assumes: we_i already includes all qualification.
module swcfg_bit_slice #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wbit_i,
    output logic          rbit_o
);

    logic mem [DEPTH];

    // Store the write bit at the addressed cell on the clock edge.
    always_ff @(posedge clk) begin
        if (we_i)
            mem[addr_i] <= wbit_i;
    end

    // Combinational read of the addressed cell.
    always_comb rbit_o = mem[addr_i];

    // R4: a write lands at its address
    a_r4_store: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem[$past(addr_i)] == $past(wbit_i)));

    // R6: without a write the addressed cell keeps its value
    a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && !$isunknown(mem[addr_i])) |=> (mem[$past(addr_i)] == $past(mem[addr_i])));

endmodule

// File: rtl/swcfg_bank.sv
// Module: one bank of DATA_W bit slices sharing address and enable.
// Assumes: bit n of the byte lives in slice n.
module swcfg_bank #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    // One slice per data bit.
    for (genvar b = 0; b < DATA_W; b++) begin : g_slice
        swcfg_bit_slice #(.DEPTH(DEPTH)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_i   (we_i),
            .addr_i (addr_i),
            .wbit_i (wdata_i[b]),
            .rbit_o (rdata_o[b])
        );
    end

endmodule

// File: rtl/swcfg_bank_ram.sv
// Module: top of the switch-placed banked RAM expansion.
// Splits the bus into a write path and a tri-state read path, decodes the
// window and bank, and holds BANK_N banks of DEPTH x DATA_W.
// Assumes: one bus cycle per clock; rst_n is synchronous and active low.
module swcfg_bank_ram #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BANK_N = 8,
    parameter int DEPTH  = 1024,
    localparam int OFF_W = $clog2(DEPTH),
    localparam int SEL_W = $clog2(BANK_N),
    localparam int WIN_W = ADDR_W - OFF_W - SEL_W,
    localparam int SW_W  = 2 * WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW_W-1:0]   sw_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic              cyc_valid_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_oe_o,
    output logic [BANK_N-1:0] bank_ce_o
);

    logic              win_hit;
    logic [OFF_W-1:0]  off;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] bank_rd [BANK_N];
    logic [DATA_W-1:0] rd_mux;

    // Lower address bits are shared by every bank.
    always_comb off = addr_i[OFF_W-1:0];
    always_comb sel = addr_i[OFF_W +: SEL_W];

    swcfg_window_decode #(.WIN_W(WIN_W), .SEL_W(SEL_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_i        (sw_i),
        .win_bits_i  (addr_i[ADDR_W-1 -: WIN_W]),
        .sel_i       (sel),
        .cyc_valid_i (cyc_valid_i),
        .match_o     (win_hit),
        .bank_ce_o   (bank_ce_o)
    );

    // Banks: write enable is the bank enable on a write outside reset.
    for (genvar k = 0; k < BANK_N; k++) begin : g_bank
        swcfg_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (bank_ce_o[k] && !rd_i && rst_n),
            .addr_i  (off),
            .wdata_i (wdata_i),
            .rdata_o (bank_rd[k])
        );
    end

    // Read path: OR together the bank outputs gated by their enables.
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < BANK_N; k++)
            if (bank_ce_o[k])
                rd_mux = rd_mux | bank_rd[k];
    end

    // Tri-state read driver for valid matched reads only.
    always_comb rdata_oe_o = win_hit && cyc_valid_i && rd_i;
    assign rdata_o = rdata_oe_o ? rd_mux : {DATA_W{1'bz}};

    // R5: the driver is only on during a valid read
    a_r5_oe_read: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe_o |-> (cyc_valid_i && rd_i && (bank_ce_o != '0)));

    // R1: a driven read always has a bank enabled for the addressed field
    a_r1_ce_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_ce_o != '0) |-> bank_ce_o[addr_i[OFF_W +: SEL_W]]);

endmodule

// File: tb/swcfg_bank_ram_bench.sv
module swcfg_bank_ram_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  sw_i = '0;
    logic [15:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic        rd_i = 1'b1;
    logic        cyc_valid_i = 1'b0;
    wire  [7:0]  rdata_o;
    logic        rdata_oe_o;
    logic [7:0]  bank_ce_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    swcfg_bank_ram u_swcfg_bank_ram (
        .clk(clk), .rst_n(rst_n), .sw_i(sw_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rd_i(rd_i), .cyc_valid_i(cyc_valid_i),
        .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o), .bank_ce_o(bank_ce_o)
    );

    function automatic logic [5:0] enc(input int base);
        logic [5:0] s;
        for (int p = 0; p < 3; p++) begin
            logic b;
            b = base[2-p];
            s[2*p]   = ~b;
            s[2*p+1] = b;
        end
        return s;
    endfunction

    function automatic logic [7:0] pat(input int k, input int o, input int seed);
        return 8'((k * 37) + (o * 3) + seed);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; rd_i = 0; cyc_valid_i = 1;
        @(negedge clk);
        cyc_valid_i = 0; rd_i = 1;
    endtask

    // Read and check data, enable and bank enables in the same cycle.
    task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] d,
                          input bit hit);
        @(negedge clk);
        addr_i = a; rd_i = 1; cyc_valid_i = 1;
        #1;
        check(req, {24'd0, rdata_o}, hit ? {24'd0, d} : {24'd0, 8'hzz});
        check(req, {31'd0, rdata_oe_o}, {31'd0, hit});
        check(req, {24'd0, bank_ce_o}, hit ? (32'd1 << a[12:10]) : 32'd0);
        cyc_valid_i = 0;
    endtask

    task automatic t_reset;
        // R5 / R3: idle outputs during reset
        #1;
        check("R5 reset oe", {31'd0, rdata_oe_o}, 0);
        check("R5 reset z", {24'd0, rdata_o}, {24'd0, 8'hzz});
        check("R3 reset ce", {24'd0, bank_ce_o}, 0);
        @(negedge clk); rst_n = 1;
        sw_i = enc(0);
        wr(16'h0000, 8'h5A);
        // R7: write attempted under reset is dropped
        @(negedge clk); rst_n = 0;
        wr(16'h0000, 8'hA5);
        @(negedge clk); rst_n = 1;
        rd_chk("R7 write under reset", 16'h0000, 8'h5A, 1);
    endtask

    task automatic t_sweep(input int base, input int seed);
        int offs [3] = '{0, 'h155, 'h3FF};
        for (int k = 0; k < 8; k++)
            for (int i = 0; i < 3; i++)
                wr(16'((base << 13) | (k << 10) | offs[i]), pat(k, offs[i], seed));
        // R1 R3 R4 R5: every bank returns its own pattern
        for (int k = 0; k < 8; k++)
            for (int i = 0; i < 3; i++)
                rd_chk("R4 sweep", 16'((base << 13) | (k << 10) | offs[i]),
                       pat(k, offs[i], seed), 1);
    endtask

    task automatic t_outside;
        sw_i = enc(1);
        wr(16'h2000 | 16'h0412, 8'h3C);
        // R6: writes one window away do not land
        wr(16'h0000 | 16'h0412, 8'hC3);
        wr(16'h4000 | 16'h0412, 8'h99);
        // R1 / R5: outside reads leave the bus floating
        rd_chk("R1 outside low", 16'h0412, 8'h00, 0);
        rd_chk("R1 outside high", 16'hE412, 8'h00, 0);
        rd_chk("R6 outside no write", 16'h2412, 8'h3C, 1);
    endtask

    task automatic t_invalid;
        logic [5:0] bad [3] = '{6'b000011, 6'b110110, 6'b011000};
        sw_i = enc(3);
        wr(16'h6008, 8'h71);
        for (int j = 0; j < 3; j++) begin
            sw_i = bad[j];
            for (int b = 0; b < 8; b++) begin
                wr(16'((b << 13) | 16'h0008), 8'h8E);
                // R2: illegal pair never responds
                rd_chk("R2 bad switches", 16'((b << 13) | 16'h0008), 8'h00, 0);
            end
        end
        sw_i = enc(3);
        rd_chk("R2 no write with bad switches", 16'h6008, 8'h71, 1);
    endtask

    task automatic t_novalid;
        sw_i = enc(6);
        wr(16'hC020, 8'h44);
        // R6: a write-typed cycle without valid does not store
        @(negedge clk); addr_i = 16'hC020; wdata_i = 8'hBB; rd_i = 0; cyc_valid_i = 0;
        #1;
        // R5 / R3: no valid, no drive, no enable
        check("R5 no valid oe", {31'd0, rdata_oe_o}, 0);
        check("R3 no valid ce", {24'd0, bank_ce_o}, 0);
        @(negedge clk); rd_i = 1;
        rd_chk("R6 invalid cycle", 16'hC020, 8'h44, 1);
    endtask

    task automatic t_relocate;
        sw_i = enc(2);
        wr(16'h4000 | 16'h1C7E, 8'hE1);
        // R8: contents follow the window to a new base
        sw_i = enc(5);
        rd_chk("R8 relocate", 16'hA000 | 16'h1C7E, 8'hE1, 1);
        rd_chk("R8 old base gone", 16'h4000 | 16'h1C7E, 8'h00, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        sw_i = enc(0); t_sweep(0, 1);
        sw_i = enc(3); t_sweep(3, 90);
        sw_i = enc(7); t_sweep(7, 201);
        t_outside();
        t_invalid();
        t_novalid();
        t_relocate();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule